// File: doc/BRIEF.md
# Serial Identifier Responder

This block answers a request with a fixed identifier sent one bit per clock on a single serial line. While no request is pending it stays quiet, holding the line low and its busy flag low. A request seen while quiet starts a frame: on the four clock cycles that follow, the block drives the four identifier bits, most significant first, with busy held high, and then it returns to quiet by itself.

The controller is a five-state Moore machine on a 3-bit state register with the codes idle=000, first bit=001, second bit=010, third bit=011 and fourth bit=100. Its outputs depend only on the state, so each bit is stable for a full cycle. A request that arrives during a frame is ignored. A request that is still high when the machine is back in idle starts the next frame one edge later, so frames sent back to back have exactly one idle cycle between them. The identifier defaults to 1101 and can be changed with a parameter.

Top module: `sid_responder`

## Requirements
- R1: While the synchronous reset `rst` is high at a rising edge, the machine enters idle, and after that edge `busy_o` and `sdo_o` are both 0.
- R2: In idle, a rising edge with `req_i` low leaves the machine in idle, so `busy_o` stays 0.
- R3: In idle, a rising edge with `req_i` high starts a frame: in the next cycle `busy_o` is 1 and `sdo_o` carries bit 3 of the identifier.
- R4: In the four frame cycles, `sdo_o` carries identifier bits 3, 2, 1 and 0 in that order. With the default identifier 4'b1101 the line reads 1, 1, 0, 1.
- R5: `busy_o` stays high for exactly four consecutive cycles per frame, and the machine returns to idle unconditionally after the fourth.
- R6: `req_i` has no effect during a frame. It neither lengthens the frame nor restarts it, and `busy_o` falls after the fourth bit even when `req_i` is high at that edge.
- R7: When `req_i` is high in the idle cycle that follows a frame, a new frame starts at the next edge, so a request held high gives frames separated by exactly one idle cycle.
- R8: Whenever `busy_o` is 0, `sdo_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 1 | Identifier request, sampled at each rising edge while idle |
| sdo_o | output | 1 | Serial identifier data, low when idle |
| busy_o | output | 1 | High during the four frame cycles |

## Verification
The hardest case to set up is a request that lands exactly on the edge where the fourth bit ends. That edge decides whether the request is dropped, because the machine is still in a frame, or would start a frame if the design wrongly treated that edge as idle. The stimulus places request pulses at each frame position, holds the request high across several frames to cover the back-to-back restart, asserts reset in the middle of a frame, and then drives a long pseudo-random request pattern. A behavioural position counter in the bench predicts both outputs on every cycle.

// File: rtl/sid_pkg.sv
`timescale 1ns/1ps
package sid_pkg;

    localparam int STATE_W = 3;
    localparam int ID_W    = 4;
    localparam logic [ID_W-1:0] ID_DEFAULT = 4'b1101;

    // Encoding is fixed: idle and four transmit positions in sequence.
    typedef enum logic [STATE_W-1:0] {
        ST_IDLE = 3'b000,
        ST_TX0  = 3'b001,
        ST_TX1  = 3'b010,
        ST_TX2  = 3'b011,
        ST_TX3  = 3'b100
    } sid_state_e;

    typedef struct packed {
        logic sdo;
        logic busy;
    } sid_out_t;

    // Index of the identifier bit driven in a transmit state (MSB first).
    function automatic logic [1:0] tx_bit_index(input sid_state_e st);
        case (st)
            ST_TX0:  tx_bit_index = 2'd3;
            ST_TX1:  tx_bit_index = 2'd2;
            ST_TX2:  tx_bit_index = 2'd1;
            default: tx_bit_index = 2'd0;
        endcase
    endfunction

    function automatic logic is_tx_state(input sid_state_e st);
        case (st)
            ST_TX0, ST_TX1, ST_TX2, ST_TX3: is_tx_state = 1'b1;
            default:                        is_tx_state = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/sid_next_state.sv
`timescale 1ns/1ps
module sid_next_state
    import sid_pkg::*;
(
    input  sid_state_e cur_st,
    input  logic       req,
    output sid_state_e nxt_st
);
    always_comb begin
        case (cur_st)
            ST_IDLE: nxt_st = req ? ST_TX0 : ST_IDLE;
            ST_TX0:  nxt_st = ST_TX1;
            ST_TX1:  nxt_st = ST_TX2;
            ST_TX2:  nxt_st = ST_TX3;
            ST_TX3:  nxt_st = ST_IDLE;
            // Any code outside the five used ones falls back to idle.
            default: nxt_st = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/sid_state_reg.sv
`timescale 1ns/1ps
module sid_state_reg
    import sid_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  sid_state_e nxt_st,
    output sid_state_e cur_st
);
    always_ff @(posedge clk) begin
        if (rst) cur_st <= ST_IDLE;
        else     cur_st <= nxt_st;
    end
endmodule

// File: rtl/sid_out_decode.sv
`timescale 1ns/1ps
module sid_out_decode
    import sid_pkg::*;
#(
    parameter logic [ID_W-1:0] ID_CODE = ID_DEFAULT
) (
    input  sid_state_e cur_st,
    output sid_out_t   outs
);
    logic active;

    always_comb begin
        active    = is_tx_state(cur_st);
        outs.busy = active;
        outs.sdo  = active & ID_CODE[tx_bit_index(cur_st)];
    end
endmodule

// File: rtl/sid_responder.sv
`timescale 1ns/1ps
module sid_responder
    import sid_pkg::*;
#(
    parameter logic [ID_W-1:0] ID_CODE = ID_DEFAULT
) (
    input  logic clk,
    input  logic rst,
    input  logic req_i,
    output logic sdo_o,
    output logic busy_o
);
    sid_state_e state_q;
    sid_state_e state_d;
    sid_out_t   outs;

    sid_next_state u_next (
        .cur_st (state_q),
        .req    (req_i),
        .nxt_st (state_d)
    );

    sid_state_reg u_reg (
        .clk    (clk),
        .rst    (rst),
        .nxt_st (state_d),
        .cur_st (state_q)
    );

    sid_out_decode #(.ID_CODE(ID_CODE)) u_dec (
        .cur_st (state_q),
        .outs   (outs)
    );

    assign sdo_o  = outs.sdo;
    assign busy_o = outs.busy;
endmodule

// File: rtl/sid_responder_chk.sv
`timescale 1ns/1ps
module sid_responder_chk #(
    parameter logic [3:0] ID = 4'b1101
) (
    input logic clk,
    input logic rst,
    input logic req_i,
    input logic sdo_o,
    input logic busy_o
);
    // Consecutive busy cycles before the current one.
    logic [2:0] run_q;

    always_ff @(posedge clk) begin
        if (rst)         run_q <= 3'd0;
        else if (busy_o) run_q <= run_q + 3'd1;
        else             run_q <= 3'd0;
    end

    // R1
    rst_idle_chk: assert property (@(posedge clk)
        rst |=> (!busy_o && !sdo_o));

    // R2
    hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !req_i) |=> !busy_o);

    // R3
    start_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && req_i) |=> (busy_o && (sdo_o == ID[3])));

    // R4
    bit_order_chk: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> (sdo_o == ID[2'd3 - run_q[1:0]]));

    // R5
    frame_len_chk: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> (run_q < 3'd4));

    // R5
    frame_end_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && run_q != 3'd3) |=> busy_o);

    // R6
    req_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && req_i && run_q == 3'd3) |=> !busy_o);

    // R7
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && req_i && $past(busy_o)) |=> busy_o);

    // R8
    quiet_line_chk: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> !sdo_o);
endmodule

bind sid_responder sid_responder_chk #(.ID(ID_CODE)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .req_i  (req_i),
    .sdo_o  (sdo_o),
    .busy_o (busy_o)
);

// File: tb/sid_responder_tb_top.sv
`timescale 1ns/1ps
module sid_responder_tb_top;

    localparam logic [3:0] ID = 4'b1101;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req = 1'b0;
    logic sdo;
    logic busy;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    // Reference model: 0 = idle, 1..4 = frame position.
    int pos = 0;
    int prev_pos = 0;
    bit rst_seen = 1'b0;
    string phase = "";

    always #2.5 clk = ~clk;

    sid_responder #(.ID_CODE(ID)) dut_i (
        .clk    (clk),
        .rst    (rst),
        .req_i  (req),
        .sdo_o  (sdo),
        .busy_o (busy)
    );

    always @(posedge clk) begin
        cycles++;
        prev_pos = pos;
        rst_seen = rst;
        if (rst)                    pos = 0;
        else if (pos == 0 && req)   pos = 1;
        else if (pos == 4)          pos = 0;
        else if (pos != 0)          pos = pos + 1;
    end

    task automatic compare();
        string tag;
        logic exp_busy;
        logic exp_sdo;
        exp_busy = (pos != 0);
        exp_sdo  = (pos != 0) ? ID[4 - pos] : 1'b0;
        if (rst_seen)                        tag = "R1";
        else if (phase != "")                tag = phase;
        else if (pos == 1)                   tag = "R3";
        else if (pos > 1)                    tag = "R4";
        else if (prev_pos == 4)              tag = "R5";
        else if (prev_pos == 0)              tag = "R2";
        else                                 tag = "R8";
        n_checks++;
        if (busy !== exp_busy || sdo !== exp_sdo) begin
            n_fail++;
            $display("FAIL %s: busy=%b sdo=%b expected busy=%b sdo=%b (pos %0d)",
                     tag, busy, sdo, exp_busy, exp_sdo, pos);
        end
    endtask

    task automatic step(input logic r, input logic rs);
        @(negedge clk);
        compare();
        req = r;
        rst = rs;
    endtask

    initial begin
        logic [7:0] lfsr;
        lfsr = 8'hA5;
        // R1: reset holds the block quiet
        phase = "R1";
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1);
        phase = "";
        // R2: idle with no request
        for (int i = 0; i < 5; i++) step(1'b0, 1'b0);
        // R3, R4, R5, R8: one single-cycle request
        step(1'b1, 1'b0);
        for (int i = 0; i < 8; i++) step(1'b0, 1'b0);
        // R6: requests at every frame position, including the last-bit edge
        step(1'b1, 1'b0);
        phase = "R6";
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0);
        for (int i = 0; i < 6; i++) step(1'b0, 1'b0);
        // R6: request only at the fourth-bit edge
        phase = "";
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        phase = "R6";
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        // R7: request held high across several frames
        phase = "R7";
        for (int i = 0; i < 16; i++) step(1'b1, 1'b0);
        for (int i = 0; i < 6; i++) step(1'b0, 1'b0);
        // R1: reset in the middle of a frame
        phase = "";
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b1);
        step(1'b0, 1'b0);
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0);
        // Pseudo-random request pattern
        for (int i = 0; i < 300; i++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            step(lfsr[0] & lfsr[2], 1'b0);
        end
        step(1'b0, 1'b0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        wait (cycles >= 100000);
        n_fail++;
        $display("FAIL watchdog: run did not finish, cycles=%0d expected below 100000", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule